// File: doc/BRIEF.md
# Audio Converter Start-Up Output Sequencer

This block sits between the decimation filter of a stereo audio converter and its output formatter. It decides when the filtered left and right sample words may be released. While the active-low power-down pin is held low, the block stays in a power-down phase. In that phase it asserts a reset to the filter and drives both channels to two's complement zero.

Once power-down is released, the block enters an initialization phase. In this phase it counts frame-clock periods, and both channels stay at zero throughout. After a fixed number of counted frame edges, the block enters normal operation. It then passes the incoming words through unchanged and raises a data-valid flag. A mode input selects which frame-clock edge is counted: rising or falling.

The frame clock is brought into the master-clock domain through a two-flop synchronizer. The power-down pin takes effect immediately when it goes low, but its release is aligned to the master clock. Pulling power-down low at any time returns the block to power-down and discards any partial count.

Top module: `adc_init_seq`

## Requirements
- R1: While the power-down input is low, the phase output reads 00, the filter-reset output is 1, data-valid is 0 and both sample outputs are zero, whatever the sample inputs carry.
- R2: After power-down is released, the phase output reads 01, data-valid is 0 and both sample outputs stay zero with nonzero sample inputs, until the final counted frame edge.
- R3: With the edge-select input at 0, only rising frame-clock edges are counted. Data-valid stays low after 4128 counted edges, and becomes high (with phase 10) within three master-clock cycles of the 4129th rising edge.
- R4: With the edge-select input at 1, only falling frame-clock edges are counted. The same 4128/4129 boundary holds for falling edges.
- R5: In normal operation the phase output reads 10, filter-reset is 0, data-valid is 1, and each sample output equals its sample input in the same cycle.
- R6: Pulling power-down low during initialization returns the block to phase 00 at once. Frame edges seen while power-down is low are not counted. After the next release, a full 4129 counted edges are again needed.
- R7: Pulling power-down low during normal operation returns the block to phase 00 with zero outputs and data-valid low. The phase value 11 never appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk | input | 1 | Master clock; all state changes on its rising edge |
| pwr_dn_n | input | 1 | Active-low power-down, asynchronous assert |
| fclk | input | 1 | Frame (left/right) clock, asynchronous to mclk |
| fall_mode | input | 1 | 0: count rising frame edges, 1: count falling |
| left_in | input | SAMPLE_W | Left sample word from the filter |
| right_in | input | SAMPLE_W | Right sample word from the filter |
| left_out | output | SAMPLE_W | Gated left sample word |
| right_out | output | SAMPLE_W | Gated right sample word |
| data_valid | output | 1 | High only in normal operation |
| phase | output | 2 | 00 power-down, 01 initialize, 10 normal |
| filt_rst | output | 1 | Filter reset, high in power-down |

## Verification
The bench builds the block with its default values: a 24-bit sample width and an initialization length of 4129 frame edges. With these values the exact 4128/4129 boundary is checked for both edge polarities. The frame clock runs at eight master-clock cycles per period, so one full initialization takes about 33,000 master cycles. This makes room for three complete counts, one aborted count and frame activity during power-down, all in one run.

// File: rtl/adc_init_seq.sv
module adc_init_seq #(
  parameter int SAMPLE_W    = 24,
  parameter int INIT_FRAMES = 4129
) (
  input  logic                mclk,
  input  logic                pwr_dn_n,
  input  logic                fclk,
  input  logic                fall_mode,
  input  logic [SAMPLE_W-1:0] left_in,
  input  logic [SAMPLE_W-1:0] right_in,
  output logic [SAMPLE_W-1:0] left_out,
  output logic [SAMPLE_W-1:0] right_out,
  output logic                data_valid,
  output logic [1:0]          phase,
  output logic                filt_rst
);
  localparam int CW = $clog2(INIT_FRAMES + 1);
  localparam logic [CW-1:0] LAST = CW'(INIT_FRAMES - 1);
  localparam logic [1:0] PH_DOWN = 2'b00;
  localparam logic [1:0] PH_INIT = 2'b01;
  localparam logic [1:0] PH_RUN  = 2'b10;

  logic [1:0]    rst_pipe;
  logic          run_n;
  logic [2:0]    fsync;
  logic [2:0]    armed;
  logic          hit;
  logic [CW-1:0] cnt;
  logic [1:0]    ph;

  always_ff @(posedge mclk or negedge pwr_dn_n)
    if (!pwr_dn_n) rst_pipe <= 2'b00;
    else           rst_pipe <= {rst_pipe[0], 1'b1};

  assign run_n = rst_pipe[1];

  always_ff @(posedge mclk or negedge run_n)
    if (!run_n) begin
      fsync <= 3'b000;
      armed <= 3'b000;
    end else begin
      fsync <= {fsync[1:0], fclk};
      armed <= {armed[1:0], 1'b1};
    end

  assign hit = armed[2] & (fall_mode ? (fsync[2] & ~fsync[1])
                                     : (fsync[1] & ~fsync[2]));

  always_ff @(posedge mclk or negedge run_n)
    if (!run_n) begin
      ph  <= PH_DOWN;
      cnt <= '0;
    end else begin
      case (ph)
        PH_DOWN: ph <= PH_INIT;
        PH_INIT: if (hit) begin
          if (cnt == LAST) ph <= PH_RUN;
          else             cnt <= cnt + 1'b1;
        end
        default: ;
      endcase
    end

  assign phase      = ph;
  assign data_valid = (ph == PH_RUN);
  assign filt_rst   = (ph == PH_DOWN);
  assign left_out   = data_valid ? left_in  : '0;
  assign right_out  = data_valid ? right_in : '0;
endmodule

// File: rtl/adc_init_seq_chk.sv
module adc_init_seq_chk #(
  parameter int SAMPLE_W = 24
) (
  input logic                mclk,
  input logic                pwr_dn_n,
  input logic [SAMPLE_W-1:0] left_in,
  input logic [SAMPLE_W-1:0] right_in,
  input logic [SAMPLE_W-1:0] left_out,
  input logic [SAMPLE_W-1:0] right_out,
  input logic                data_valid,
  input logic [1:0]          phase,
  input logic                filt_rst
);
  always @(posedge mclk) begin
    if (pwr_dn_n === 1'b0)
      a_r1_down_quiet: assert (phase == 2'b00 && filt_rst && !data_valid &&
                               left_out == '0 && right_out == '0);
    if (pwr_dn_n === 1'b1)
      a_r7_no_bad_phase: assert (phase != 2'b11);
  end

  a_r2_init_zero: assert property (@(posedge mclk) disable iff (!pwr_dn_n)
    phase == 2'b01 |-> (left_out == '0 && right_out == '0 && !data_valid));

  a_r5_run_pass: assert property (@(posedge mclk) disable iff (!pwr_dn_n)
    data_valid |-> (left_out == left_in && right_out == right_in &&
                    phase == 2'b10 && !filt_rst));

  a_r3_run_from_init: assert property (@(posedge mclk) disable iff (!pwr_dn_n)
    $rose(data_valid) |-> $past(phase) == 2'b01);

  a_r7_run_holds: assert property (@(posedge mclk) disable iff (!pwr_dn_n)
    $past(phase) == 2'b10 |-> phase == 2'b10);
endmodule

bind adc_init_seq adc_init_seq_chk #(.SAMPLE_W(SAMPLE_W)) chk_i (
  .mclk(mclk), .pwr_dn_n(pwr_dn_n), .left_in(left_in), .right_in(right_in),
  .left_out(left_out), .right_out(right_out), .data_valid(data_valid),
  .phase(phase), .filt_rst(filt_rst)
);

// File: tb/adc_init_seq_tb_top.sv
module adc_init_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 24;
  localparam int N = 4129;

  logic         mclk = 1'b0;
  logic         pwr_dn_n = 1'b0;
  logic         fclk = 1'b0;
  logic         fall_mode = 1'b0;
  logic [W-1:0] left_in = '0;
  logic [W-1:0] right_in = '0;
  logic [W-1:0] left_out, right_out;
  logic         data_valid, filt_rst;
  logic [1:0]   phase;

  int checks = 0;
  int failures = 0;
  int counted = 0;
  bit done = 0;

  adc_init_seq #(.SAMPLE_W(W), .INIT_FRAMES(N)) dut_i (
    .mclk(mclk), .pwr_dn_n(pwr_dn_n), .fclk(fclk), .fall_mode(fall_mode),
    .left_in(left_in), .right_in(right_in), .left_out(left_out),
    .right_out(right_out), .data_valid(data_valid), .phase(phase),
    .filt_rst(filt_rst)
  );

  always #(CLK_PERIOD/2) mclk = ~mclk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic half_frame();
    @(negedge mclk);
    fclk = ~fclk;
    if (fclk == !fall_mode) counted++;
    repeat (3) @(negedge mclk);
  endtask

  task automatic check_down(input string req);
    #1;
    check({req, " phase"}, 64'(phase), 64'd0);
    check({req, " filt_rst"}, 64'(filt_rst), 64'd1);
    check({req, " valid"}, 64'(data_valid), 64'd0);
    check({req, " outs"}, {16'd0, left_out, right_out}, 64'd0);
  endtask

  task automatic release_pd(input logic fm, input string req);
    @(negedge mclk);
    fclk = 1'b0;
    fall_mode = fm;
    left_in = 24'h5A5A5A;
    right_in = 24'hA11111;
    pwr_dn_n = 1'b1;
    counted = 0;
    repeat (10) @(negedge mclk);
    check({req, " init phase"}, 64'(phase), 64'd1);
    check({req, " init zero"}, {16'd0, left_out, right_out}, 64'd0);
  endtask

  task automatic full_count(input string req);
    while (counted < N - 1) half_frame();
    check({req, " valid low at N-1"}, 64'(data_valid), 64'd0);
    check({req, " phase at N-1"}, 64'(phase), 64'd1);
    check({req, " zero at N-1"}, {16'd0, left_out, right_out}, 64'd0);
    while (counted < N) half_frame();
    check({req, " valid high at N"}, 64'(data_valid), 64'd1);
    check({req, " phase at N"}, 64'(phase), 64'd2);
  endtask

  task automatic test_r1_reset();
    left_in = 24'hFFFFFF;
    right_in = 24'h123456;
    repeat (5) @(negedge mclk);
    check_down("R1");
  endtask

  task automatic test_r3_rising();
    release_pd(1'b0, "R2");
    full_count("R3");
    @(negedge mclk);
    left_in = 24'h800000; right_in = 24'h7FFFFF;
    #1 check("R5 left", 64'(left_out), 64'h800000);
    check("R5 right", 64'(right_out), 64'h7FFFFF);
    check("R5 filt_rst", 64'(filt_rst), 64'd0);
    @(negedge mclk);
    left_in = 24'h000001; right_in = 24'hFEDCBA;
    #1 check("R5 left2", 64'(left_out), 64'h000001);
    check("R5 right2", 64'(right_out), 64'hFEDCBA);
    repeat (20) half_frame();
    check("R5 stays run", 64'(phase), 64'd2);
  endtask

  task automatic test_r7_drop_from_run();
    @(negedge mclk);
    pwr_dn_n = 1'b0;
    check_down("R7");
    repeat (3) @(negedge mclk);
    check("R7 held", 64'(phase), 64'd0);
  endtask

  task automatic test_r4_falling();
    release_pd(1'b1, "R4");
    full_count("R4");
    @(negedge mclk);
    pwr_dn_n = 1'b0;
    check_down("R4 drop");
  endtask

  task automatic test_r6_abort();
    release_pd(1'b0, "R6");
    while (counted < 100) half_frame();
    check("R6 mid init", 64'(phase), 64'd1);
    @(negedge mclk);
    pwr_dn_n = 1'b0;
    check_down("R6");
    for (int i = 0; i < 100; i++) half_frame();
    check("R6 edges ignored", 64'(phase), 64'd0);
    release_pd(1'b0, "R6");
    full_count("R6");
  endtask

  initial begin
    repeat (200000) @(posedge mclk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    test_r1_reset();
    test_r3_rising();
    test_r7_drop_from_run();
    test_r4_falling();
    test_r6_abort();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule